// File: doc/BRIEF.md
# SYSREF-Aligned Extended-Multiblock Phase Counter

This block keeps the local extended-multiblock phase of a receive link. A counter on the link clock runs from 0 to `EMB_COUNT*32-1` and wraps, producing a one-cycle boundary pulse at each wrap. A synchronized SYSREF input realigns the counter: on a sampled rising edge the counter reloads a programmable offset instead of zero. This lets a system shift the effective SYSREF phase when the converter and the logic device see the edge at different times.

Realignment has two modes. The first is a one-shot arm bit that is set at reset, is consumed by the first qualifying edge and can be re-armed. The second is a continuous mode in which every rising edge realigns. In continuous mode the block also checks that consecutive edges are a whole number of counter periods apart and pulses an error when they are not. Until the first edge has been taken, a pending flag stays high and the marker gate stays closed, so downstream logic emits no end-of-extended-multiblock marker. A link reinit request restarts the counter and drops the period reference but keeps the record that SYSREF was seen.

Top module: `lemc_align`

## Requirements
- R1: After reset the counter advances by one each clock, stays within 0..P-1 (P = EMB_COUNT*32) and goes from P-1 to 0.
- R2: `lemcWrap` is high for exactly the one cycle in which the counter shows 0 after stepping from P-1. A realignment load never raises it.
- R3: When a SYSREF rise (input high this clock, low the clock before) is taken, the counter shows `offsetVal` in the next cycle. An offset above P-1 loads 0 instead.
- R4: `armState` is 1 after reset. A rise taken while it is 1 clears it at that same edge. `armSet` sets it, and a set in the same cycle as a taken rise wins.
- R5: With `alwaysOn` high, every rise realigns, and a SYSREF held high realigns only once. With `alwaysOn` low and `armState` low, a rise has no effect and the counter keeps stepping.
- R6: In continuous mode, `periodErr` pulses for one cycle after a rise whose distance from the previous taken rise is not a multiple of P. The first rise after `alwaysOn` goes high is not checked.
- R7: `detPending` is high from reset until the first taken rise and then stays low until the next reset. `markerGate` is always its inverse.
- R8: A `reinitReq` pulse shows as `reinitPend` for one cycle. At the end of that cycle the counter is forced to 0 and the period reference is dropped, while `markerGate` is kept. A rise during the pending cycle is ignored.
- R9: During and right after reset, the counter, `lemcWrap`, `periodErr` and `reinitPend` are 0, and `detPending` and `armState` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sysrefIn | input | 1 | SYSREF, already synchronized to `clk` |
| armSet | input | 1 | Pulse that sets the one-shot arm bit |
| alwaysOn | input | 1 | Continuous realignment and period checking enable |
| offsetVal | input | CW | Counter value loaded on a taken SYSREF rise |
| reinitReq | input | 1 | Pulse requesting a link reinit |
| lemcCount | output | CW | Current phase counter value |
| lemcWrap | output | 1 | Boundary pulse on the wrap to 0 |
| armState | output | 1 | Current one-shot arm bit |
| detPending | output | 1 | No SYSREF edge taken since reset |
| periodErr | output | 1 | One-cycle SYSREF period error |
| markerGate | output | 1 | Marker emission allowed |
| reinitPend | output | 1 | Reinit request latched, taking effect this cycle |

## Verification
The bench builds the block with `EMB_COUNT` set to 3, which gives a period of 96 and a 7-bit counter. Because 96 is not a power of two, the explicit wrap at P-1 is exercised rather than a natural binary rollover. The offset codes 96 to 127 can also be driven, so the out-of-range reload to 0 is reachable. The period table mixes gaps of one, two and three periods with gaps one cycle short or long and an unrelated gap.

// File: rtl/lemc_pkg.sv
package lemc_pkg;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic loadOffset;  // realign: load the programmed offset
    logic clearCount;  // reinit: force the counter to zero
  } lemc_strobe_t;

endpackage

// File: rtl/lemc_ctrl.sv
module lemc_ctrl
  import lemc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sysrefIn,
  input  logic         armSet,
  input  logic         alwaysOn,
  input  logic         reinitReq,
  input  logic         phaseOk,
  output lemc_strobe_t strobe,
  output logic         armState,
  output logic         seenEdge,
  output logic         periodErr,
  output logic         reinitPend
);

  logic prevSys;
  logic armBit;
  logic seenBit;
  logic refValid;
  logic errPulse;
  logic reqBit;
  logic rise;
  logic takeEdge;

  assign rise     = sysrefIn & ~prevSys;
  // a pending reinit owns this cycle; edges in it are dropped
  assign takeEdge = rise & (armBit | alwaysOn) & ~reqBit;

  always_comb begin
    strobe            = '0;
    strobe.loadOffset = takeEdge;
    strobe.clearCount = reqBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSys  <= 1'b0;
      armBit   <= 1'b1;
      seenBit  <= 1'b0;
      refValid <= 1'b0;
      errPulse <= 1'b0;
      reqBit   <= 1'b0;
    end else begin
      prevSys <= sysrefIn;
      reqBit  <= reinitReq;

      if (armSet)        armBit <= 1'b1;
      else if (takeEdge) armBit <= 1'b0;

      if (takeEdge) seenBit <= 1'b1;

      if (reqBit || !alwaysOn) refValid <= 1'b0;
      else if (takeEdge)       refValid <= 1'b1;

      errPulse <= takeEdge & alwaysOn & refValid & ~phaseOk;
    end
  end

  assign armState   = armBit;
  assign seenEdge   = seenBit;
  assign periodErr  = errPulse;
  assign reinitPend = reqBit;

endmodule

// File: rtl/lemc_datapath.sv
module lemc_datapath
  import lemc_pkg::*;
#(
  parameter int EMB_COUNT = 2,
  localparam int PERIOD   = EMB_COUNT * 32,
  localparam int CW       = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rstN,
  input  lemc_strobe_t  strobe,
  input  logic [CW-1:0] offsetVal,
  output logic [CW-1:0] lemcCount,
  output logic          lemcWrap,
  output logic          phaseOk
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] countQ;
  logic          wrapQ;
  logic [CW-1:0] nextFree;
  logic [CW-1:0] loadVal;

  assign nextFree = (countQ == LAST) ? '0 : countQ + 1'b1;
  assign loadVal  = (offsetVal > LAST) ? '0 : offsetVal;
  // edge lands where the free-running counter would have put it anyway
  assign phaseOk  = (nextFree == loadVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      wrapQ  <= 1'b0;
    end else if (strobe.clearCount) begin
      countQ <= '0;
      wrapQ  <= 1'b0;
    end else if (strobe.loadOffset) begin
      countQ <= loadVal;
      wrapQ  <= 1'b0;
    end else begin
      countQ <= nextFree;
      wrapQ  <= (countQ == LAST);
    end
  end

  assign lemcCount = countQ;
  assign lemcWrap  = wrapQ;

endmodule

// File: rtl/lemc_align.sv
module lemc_align
  import lemc_pkg::*;
#(
  parameter int EMB_COUNT = 2,
  localparam int PERIOD   = EMB_COUNT * 32,
  localparam int CW       = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sysrefIn,
  input  logic          armSet,
  input  logic          alwaysOn,
  input  logic [CW-1:0] offsetVal,
  input  logic          reinitReq,
  output logic [CW-1:0] lemcCount,
  output logic          lemcWrap,
  output logic          armState,
  output logic          detPending,
  output logic          periodErr,
  output logic          markerGate,
  output logic          reinitPend
);

  lemc_strobe_t strobe;
  logic         phaseOk;
  logic         seenEdge;

  lemc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sysrefIn   (sysrefIn),
    .armSet     (armSet),
    .alwaysOn   (alwaysOn),
    .reinitReq  (reinitReq),
    .phaseOk    (phaseOk),
    .strobe     (strobe),
    .armState   (armState),
    .seenEdge   (seenEdge),
    .periodErr  (periodErr),
    .reinitPend (reinitPend)
  );

  lemc_datapath #(.EMB_COUNT(EMB_COUNT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .offsetVal (offsetVal),
    .lemcCount (lemcCount),
    .lemcWrap  (lemcWrap),
    .phaseOk   (phaseOk)
  );

  assign markerGate = seenEdge;
  assign detPending = ~seenEdge;

endmodule

// File: rtl/lemc_align_check.sv
module lemc_align_check #(
  parameter int EMB_COUNT = 2,
  localparam int PERIOD   = EMB_COUNT * 32,
  localparam int CW       = $clog2(PERIOD)
) (
  input logic          clk,
  input logic          rstN,
  input logic          sysrefIn,
  input logic          armSet,
  input logic          alwaysOn,
  input logic [CW-1:0] offsetVal,
  input logic          reinitReq,
  input logic [CW-1:0] lemcCount,
  input logic          lemcWrap,
  input logic          armState,
  input logic          detPending,
  input logic          periodErr,
  input logic          markerGate,
  input logic          reinitPend
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic prevSample;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSample <= 1'b0;
    else       prevSample <= sysrefIn;
  end

  logic riseSeen;
  assign riseSeen = sysrefIn && !prevSample;

  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    lemcCount <= LAST);

  assert_wrap_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    lemcWrap |-> (lemcCount == '0 && $past(lemcCount) == LAST));

  assert_realign_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (riseSeen && alwaysOn && !reinitPend) |=>
      lemcCount == (($past(offsetVal) > LAST) ? '0 : $past(offsetVal)));

  assert_arm_consume_R4: assert property (@(posedge clk) disable iff (!rstN)
    (riseSeen && armState && !reinitPend) |=> (!armState || $past(armSet)));

  assert_err_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    periodErr |-> $past(alwaysOn));

  assert_gate_inverse_R7: assert property (@(posedge clk) disable iff (!rstN)
    markerGate == !detPending);

  assert_gate_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(markerGate));

  assert_reinit_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    reinitPend |=> (lemcCount == '0 && !reinitPend || $past(reinitReq) && lemcCount == '0));

endmodule

bind lemc_align lemc_align_check #(.EMB_COUNT(EMB_COUNT)) u_check (
  .clk        (clk),
  .rstN       (rstN),
  .sysrefIn   (sysrefIn),
  .armSet     (armSet),
  .alwaysOn   (alwaysOn),
  .offsetVal  (offsetVal),
  .reinitReq  (reinitReq),
  .lemcCount  (lemcCount),
  .lemcWrap   (lemcWrap),
  .armState   (armState),
  .detPending (detPending),
  .periodErr  (periodErr),
  .markerGate (markerGate),
  .reinitPend (reinitPend)
);

// File: tb/lemc_align_bench.sv
`timescale 1ns/1ps
module lemc_align_bench;

  localparam int E  = 3;
  localparam int P  = E * 32;
  localparam int CW = $clog2(P);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sysrefIn = 1'b0;
  logic          armSet = 1'b0;
  logic          alwaysOn = 1'b0;
  logic [CW-1:0] offsetVal = '0;
  logic          reinitReq = 1'b0;
  logic [CW-1:0] lemcCount;
  logic          lemcWrap, armState, detPending, periodErr, markerGate, reinitPend;

  lemc_align #(.EMB_COUNT(E)) u_lemc_align (
    .clk(clk), .rstN(rstN), .sysrefIn(sysrefIn), .armSet(armSet),
    .alwaysOn(alwaysOn), .offsetVal(offsetVal), .reinitReq(reinitReq),
    .lemcCount(lemcCount), .lemcWrap(lemcWrap), .armState(armState),
    .detPending(detPending), .periodErr(periodErr), .markerGate(markerGate),
    .reinitPend(reinitPend)
  );

  always #10 clk = ~clk;  // 50 MHz

  int total = 0;
  int fails = 0;

  // period table: gap between rises, offset, expected load value, expected error
  localparam int TBL[7][4] = '{
    '{96,  10, 10, 0},
    '{192,  0,  0, 0},
    '{95,   5,  5, 1},
    '{97,  95, 95, 1},
    '{288, 50, 50, 0},
    '{96, 100,  0, 0},
    '{40, 127,  0, 1}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int actual, int expected);
    total++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  initial begin
    #(20 * 150000);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int c;
    int guard;
    // R9 reset state
    repeat (3) step();
    chk("R9 count", lemcCount, 0);
    chk("R9 wrap", lemcWrap, 0);
    chk("R9 arm", armState, 1);
    chk("R9 pending", detPending, 1);
    chk("R9 err", periodErr, 0);
    chk("R9 reinit", reinitPend, 0);
    rstN = 1'b1;
    step();
    chk("R1 first step", lemcCount, 1);
    chk("R7 gate closed", markerGate, 0);

    // R1 / R2 wrap
    guard = 0;
    while (lemcCount != P - 1 && guard < 300) begin step(); guard++; end
    chk("R1 reach last", lemcCount, P - 1);
    chk("R2 no early wrap", lemcWrap, 0);
    step();
    chk("R1 wrap to zero", lemcCount, 0);
    chk("R2 wrap pulse", lemcWrap, 1);
    step();
    chk("R1 after wrap", lemcCount, 1);
    chk("R2 wrap one cycle", lemcWrap, 0);

    // R3 / R4 / R7 one-shot arm
    offsetVal = 7'd20;
    sysrefIn = 1'b1;
    step();
    sysrefIn = 1'b0;
    chk("R3 load offset", lemcCount, 20);
    chk("R4 arm consumed", armState, 0);
    chk("R7 pending cleared", detPending, 0);
    chk("R7 gate open", markerGate, 1);
    chk("R6 no err one-shot", periodErr, 0);
    step();
    chk("R3 step after load", lemcCount, 21);

    // R5 ignored edge with both modes off
    repeat (5) step();
    c = lemcCount;
    sysrefIn = 1'b1;
    step();
    sysrefIn = 1'b0;
    chk("R5 edge ignored", lemcCount, (c + 1) % P);
    chk("R4 arm stays clear", armState, 0);

    // R4 re-arm, set wins over consume
    step();
    armSet = 1'b1;
    step();
    chk("R4 arm set", armState, 1);
    offsetVal = 7'd9;
    sysrefIn = 1'b1;
    step();
    armSet = 1'b0;
    sysrefIn = 1'b0;
    chk("R3 load with set", lemcCount, 9);
    chk("R4 set wins", armState, 1);
    step();
    offsetVal = 7'd7;
    sysrefIn = 1'b1;
    step();
    sysrefIn = 1'b0;
    chk("R3 rearmed load", lemcCount, 7);
    chk("R4 consumed again", armState, 0);

    // R5 continuous, held high realigns once
    step();
    alwaysOn = 1'b1;
    offsetVal = 7'd33;
    sysrefIn = 1'b1;
    step();
    chk("R5 continuous load", lemcCount, 33);
    chk("R6 first edge unchecked", periodErr, 0);
    step();
    chk("R5 held high once", lemcCount, 34);
    step();
    chk("R5 held high twice", lemcCount, 35);
    sysrefIn = 1'b0;

    // R8 reinit
    reinitReq = 1'b1;
    step();
    reinitReq = 1'b0;
    chk("R8 request visible", reinitPend, 1);
    step();
    chk("R8 counter cleared", lemcCount, 0);
    chk("R8 request cleared", reinitPend, 0);
    chk("R8 gate kept", markerGate, 1);
    repeat (3) step();
    sysrefIn = 1'b1;
    step();
    sysrefIn = 1'b0;
    chk("R8 load after reinit", lemcCount, 33);
    chk("R8 reference dropped", periodErr, 0);
    step();
    reinitReq = 1'b1;
    step();
    reinitReq = 1'b0;
    sysrefIn = 1'b1;
    step();
    sysrefIn = 1'b0;
    chk("R8 edge during reinit ignored", lemcCount, 0);

    // R6 / R3 period table
    for (int i = 0; i < 7; i++) begin
      alwaysOn = 1'b0;
      step();
      alwaysOn = 1'b1;
      offsetVal = CW'(TBL[i][1]);
      sysrefIn = 1'b1;
      step();
      sysrefIn = 1'b0;
      chk("R3 table first load", lemcCount, TBL[i][2]);
      chk("R6 table first unchecked", periodErr, 0);
      for (int k = 0; k < TBL[i][0] - 1; k++) step();
      sysrefIn = 1'b1;
      step();
      sysrefIn = 1'b0;
      chk("R6 table period error", periodErr, TBL[i][3]);
      chk("R3 table second load", lemcCount, TBL[i][2]);
      step();
      chk("R6 error one cycle", periodErr, 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule